// File: doc/BRIEF.md
# Log-MAP Forward Recursion and Soft-Output Unit

This block runs the forward half of a Log-MAP soft-input soft-output decoder for an eight-state recursive systematic convolutional code with a three-bit encoder memory. On each enabled clock it takes one step of the trellis. The inputs for a step are a sign-magnitude systematic value (the channel sample already combined with the a-priori value), a sign-magnitude parity sample, and the eight reverse metrics that a separate backward unit has computed for the same step. From these it updates the eight forward path metrics and produces a signed soft decision for the step.

Path metrics count penalties only. A branch that disagrees with the received signs adds the magnitude of the sample, and a branch that agrees adds nothing, so a smaller metric means a more likely path. The metrics are never renormalised. They wrap modulo 2^MW, and every compare takes the two's-complement difference of the two values. Each add-compare-select cell subtracts a small correction that depends on the gap between its two contenders. This correction is active only at the three finest output scales.

The parity tap pattern comes from a configuration input. The soft output is the smallest total over the 0-input transitions minus the smallest total over the 1-input transitions. The two minima are registered, and the subtraction and saturation happen one clock later.

Top module: `mapfw_fwd_unit`

## Requirements
- R1: `sys_in` is sign-magnitude with bit 5 as the sign, and `par_in` is sign-magnitude with bit 4 as the sign. A sign of 0 leans towards bit value 1. A branch that expects bit b is penalised by the magnitude when the sign bit equals b, and by 0 otherwise. The branch penalty is the systematic penalty for the input bit plus the parity penalty for the parity bit.
- R2: A state is {r1,r2,r3} in bits [2:0]. For input u the feedback bit is w = u^r2^r3 and the next state is {w,r1,r2}. The parity bit is poly[0]&w ^ poly[1]&r1 ^ poly[2]&r2 ^ poly[3]&r3.
- R3: Metrics are 7 bits and wrap modulo 128. In each state, the contender that comes from r3=0 wins unless (that contender minus the other), taken modulo 128 as a signed value, is positive.
- R4: `scale_code` k means a scale of 2^k. For k<3, with T = 40>>k and D = |signed difference of the contenders| (0..64), the correction is (T-D)>>3 when D<T and 0 otherwise. The new metric is the winning contender minus the correction, modulo 128. For k>=3 no correction is applied.
- R5: After reset or `clear`, state 0 holds 0 and every other state holds 32. `clear` takes priority over `step_en`. A step taken together with `clear` still feeds its soft-output stage from the metrics held before the clear.
- R6: For each state s and input u, the total is α[s]+γ+β[next], taken modulo 128. Each minimum scans s = 0..7 and replaces the current best only when (candidate − best) is negative modulo 128. The output is (min over u=0) − (min over u=1) as a 7-bit signed value, saturated to [−31, +31]. A positive output favours bit 1.
- R7: The soft output for a step whose inputs are present at one enabled edge appears after the next enabled edge.
- R8: With `step_en` low, the metrics and the output pipeline hold, and the data inputs have no effect.
- R9: On `beta_in`, the reverse metric of state j sits at bits [7j+6:7j].
- R10: While reset is held, `llr_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance one trellis step; low pauses |
| clear | input | 1 | Reload start-of-frame metrics |
| poly | input | 4 | Parity tap pattern |
| scale_code | input | 3 | Output scale exponent, 0..5 |
| sys_in | input | 6 | Sign-magnitude systematic plus a-priori value |
| par_in | input | 5 | Sign-magnitude parity sample |
| beta_in | input | 56 | Eight 7-bit reverse metrics |
| llr_out | output | 6 | Signed soft output |

## Verification
The stimulus mixes all scale codes and random tap patterns. It uses full-range metrics so that contender gaps reach the ±64 wrap boundary. A compare done as an unsigned compare, or a correction that used the wrong threshold, would then produce wrong soft outputs within a few steps. Large reverse metrics push the output into saturation at ±31, and a design that truncated instead of clamping would flip the sign. The directed phases pause with the data inputs changing, and they assert clear both with and without step_en. A design that leaked inputs through a pause, or let a clear reach the output stage early, would move the output away from the expected sequence.

// File: rtl/mapfw_pkg.sv
package mapfw_pkg;
    localparam int unsigned MEMW   = 3;
    localparam int unsigned NSTATE = 1 << MEMW;

    function automatic logic [MEMW-1:0] nxt_state(logic [MEMW-1:0] s, logic u);
        return {u ^ s[1] ^ s[0], s[2], s[1]};
    endfunction

    function automatic logic par_bit(logic [MEMW-1:0] s, logic u, logic [3:0] g);
        logic w;
        w = u ^ s[1] ^ s[0];
        return (g[0] & w) ^ (g[1] & s[2]) ^ (g[2] & s[1]) ^ (g[3] & s[0]);
    endfunction
endpackage

// File: rtl/mapfw_pen.sv
module mapfw_pen #(
    parameter int W = 6
) (
    input  logic [W-1:0] sm,
    input  logic         bit_val,
    output logic [W-2:0] pen
);
    // disagreement costs the magnitude, agreement is free
    assign pen = (sm[W-1] == bit_val) ? sm[W-2:0] : '0;
endmodule

// File: rtl/mapfw_acs.sv
module mapfw_acs #(
    parameter int MW    = 7,
    parameter int SCW   = 3,
    parameter int CBASE = 40,
    parameter int CLIM  = 3,
    parameter int CSH   = 3
) (
    input  logic [MW-1:0]  m_a,
    input  logic [MW-1:0]  m_b,
    input  logic [SCW-1:0] scale,
    output logic [MW-1:0]  m_new
);
    logic [MW-1:0] diff_w;
    logic [MW-1:0] mag_w;
    logic [MW-1:0] best_w;
    logic [MW:0]   thr_w;
    logic [MW:0]   corr_w;
    logic          b_wins;

    always_comb begin
        diff_w = m_a - m_b;
        b_wins = !diff_w[MW-1] && (diff_w != '0);
        best_w = b_wins ? m_b : m_a;
        mag_w  = diff_w[MW-1] ? (~diff_w + 1'b1) : diff_w;
        thr_w  = (MW+1)'(CBASE) >> scale;
        corr_w = '0;
        if ((scale < SCW'(CLIM)) && ({1'b0, mag_w} < thr_w))
            corr_w = (thr_w - {1'b0, mag_w}) >> CSH;
        m_new  = best_w - corr_w[MW-1:0];
    end
endmodule

// File: rtl/mapfw_minscan.sv
module mapfw_minscan #(
    parameter int MW = 7,
    parameter int N  = 8
) (
    input  logic [N-1:0][MW-1:0] vals,
    output logic [MW-1:0]        best
);
    logic [MW-1:0] d_w;

    always_comb begin
        best = vals[0];
        d_w  = '0;
        for (int i = 1; i < N; i++) begin
            d_w = vals[i] - best;
            if (d_w[MW-1]) best = vals[i];
        end
    end
endmodule

// File: rtl/mapfw_fwd_unit.sv
module mapfw_fwd_unit
    import mapfw_pkg::*;
#(
    parameter int MW    = 7,
    parameter int SYSW  = 6,
    parameter int PARW  = 5,
    parameter int OW    = 6,
    parameter int SCW   = 3,
    parameter int CBASE = 40
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_en,
    input  logic                   clear,
    input  logic [3:0]             poly,
    input  logic [SCW-1:0]         scale_code,
    input  logic [SYSW-1:0]        sys_in,
    input  logic [PARW-1:0]        par_in,
    input  logic [NSTATE*MW-1:0]   beta_in,
    output logic [OW-1:0]          llr_out
);
    localparam int NS       = NSTATE;
    localparam int INIT_PEN = 1 << (MW - 2);
    localparam int LIM      = (1 << (OW - 1)) - 1;

    typedef struct packed {
        logic [NS-1:0][MW-1:0] alpha;
        logic [MW-1:0]         min0;
        logic [MW-1:0]         min1;
        logic [OW-1:0]         llr;
    } fwd_regs_t;

    fwd_regs_t r_d, r_q;

    logic [1:0][SYSW-2:0]  spen;
    logic [1:0][PARW-2:0]  ppen;
    logic [3:0][MW-1:0]    gamma;
    logic [NS-1:0][MW-1:0] beta_v;
    logic [NS-1:0][MW-1:0] acs_new;
    logic [NS-1:0][MW-1:0] tot0, tot1;
    logic [NS-1:0][MW-1:0] start_v;
    logic [NS-1:0][MW-1:0] alpha_now;
    logic [MW-1:0]         min0_w, min1_w, ldiff_w;
    int                    llr_i;

    assign beta_v    = beta_in;
    assign alpha_now = r_q.alpha;

    // branch penalties, each formed once
    for (genvar b = 0; b < 2; b++) begin : g_pen
        mapfw_pen #(.W(SYSW)) u_spen (.sm(sys_in), .bit_val(1'(b)), .pen(spen[b]));
        mapfw_pen #(.W(PARW)) u_ppen (.sm(par_in), .bit_val(1'(b)), .pen(ppen[b]));
    end
    for (genvar c = 0; c < 4; c++) begin : g_gam
        assign gamma[c] = MW'(spen[c>>1]) + MW'(ppen[c&1]);
    end

    // one add-compare-select cell per destination state
    for (genvar n = 0; n < NS; n++) begin : g_st
        localparam logic [MEMW-1:0] NX = MEMW'(n);
        localparam logic [MEMW-1:0] SA = {NX[1], NX[0], 1'b0};
        localparam logic [MEMW-1:0] SB = {NX[1], NX[0], 1'b1};
        localparam logic            UA = NX[2] ^ NX[0];
        localparam logic            UB = ~UA;
        logic          pa, pb;
        logic [MW-1:0] ca, cb;
        assign pa = par_bit(SA, UA, poly);
        assign pb = par_bit(SB, UB, poly);
        assign ca = r_q.alpha[SA] + gamma[{UA, pa}];
        assign cb = r_q.alpha[SB] + gamma[{UB, pb}];
        mapfw_acs #(.MW(MW), .SCW(SCW), .CBASE(CBASE)) u_acs (
            .m_a(ca), .m_b(cb), .scale(scale_code), .m_new(acs_new[n])
        );
        assign start_v[n] = (n == 0) ? '0 : MW'(INIT_PEN);
    end

    // transition totals for the soft output
    for (genvar s = 0; s < NS; s++) begin : g_tot
        localparam logic [MEMW-1:0] SX = MEMW'(s);
        localparam logic [MEMW-1:0] N0 = {SX[1] ^ SX[0], SX[2], SX[1]};
        localparam logic [MEMW-1:0] N1 = {~(SX[1] ^ SX[0]), SX[2], SX[1]};
        logic q0, q1;
        assign q0      = par_bit(SX, 1'b0, poly);
        assign q1      = par_bit(SX, 1'b1, poly);
        assign tot0[s] = r_q.alpha[s] + gamma[{1'b0, q0}] + beta_v[N0];
        assign tot1[s] = r_q.alpha[s] + gamma[{1'b1, q1}] + beta_v[N1];
    end

    mapfw_minscan #(.MW(MW), .N(NS)) u_min0 (.vals(tot0), .best(min0_w));
    mapfw_minscan #(.MW(MW), .N(NS)) u_min1 (.vals(tot1), .best(min1_w));

    always_comb begin
        r_d     = r_q;
        ldiff_w = r_q.min0 - r_q.min1;
        llr_i   = int'($signed(ldiff_w));
        if (llr_i > LIM)  llr_i = LIM;
        if (llr_i < -LIM) llr_i = -LIM;
        if (step_en) begin
            r_d.alpha = acs_new;
            r_d.min0  = min0_w;
            r_d.min1  = min1_w;
            r_d.llr   = OW'(llr_i);
        end
        if (clear) r_d.alpha = start_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.alpha <= start_v;
            r_q.min0  <= '0;
            r_q.min1  <= '0;
            r_q.llr   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign llr_out = r_q.llr;
endmodule

// File: rtl/mapfw_fwd_chk.sv
module mapfw_fwd_chk #(
    parameter int NS = 8,
    parameter int MW = 7,
    parameter int OW = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  step_en,
    input logic                  clear,
    input logic [OW-1:0]         llr_out,
    input logic [NS-1:0][MW-1:0] alpha
);
    logic [NS-1:0][MW-1:0] start_c;
    always_comb begin
        for (int i = 0; i < NS; i++)
            start_c[i] = (i == 0) ? '0 : MW'(1 << (MW - 2));
    end

    p_clear_start_r5: assert property (@(posedge clk) disable iff (rst)
        clear |=> (alpha == start_c));

    p_pause_alpha_r8: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !clear) |=> $stable(alpha));

    p_pause_llr_r8: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(llr_out));

    p_llr_sym_r6: assert property (@(posedge clk) disable iff (rst)
        llr_out != {1'b1, {(OW-1){1'b0}}});
endmodule

bind mapfw_fwd_unit mapfw_fwd_chk #(.NS(NS), .MW(MW), .OW(OW)) u_chk (
    .clk(clk), .rst(rst), .step_en(step_en), .clear(clear),
    .llr_out(llr_out), .alpha(alpha_now)
);

// File: tb/mapfw_fwd_unit_test.sv
module mapfw_fwd_unit_test;
    logic        clk = 0;
    logic        rst, step_en, clear;
    logic [3:0]  poly;
    logic [2:0]  scale_code;
    logic [5:0]  sys_in;
    logic [4:0]  par_in;
    logic [55:0] beta_in;
    logic [5:0]  llr_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_al[8];
    int m_mn0, m_mn1, m_llr;
    int n_al[8];
    int n_mn0, n_mn1;

    always #4 clk = ~clk;

    mapfw_fwd_unit uut (
        .clk(clk), .rst(rst), .step_en(step_en), .clear(clear), .poly(poly),
        .scale_code(scale_code), .sys_in(sys_in), .par_in(par_in),
        .beta_in(beta_in), .llr_out(llr_out)
    );

    function automatic int m7(int x); return x & 127; endfunction
    function automatic int s7(int x);
        int v = x & 127;
        return (v >= 64) ? v - 128 : v;
    endfunction
    function automatic int penf(int sm, int w, int b);
        int sg = (sm >> (w - 1)) & 1;
        int mg = sm & ((1 << (w - 1)) - 1);
        return (sg == b) ? mg : 0;
    endfunction
    function automatic int nxtf(int s, int u);
        int w = (u ^ (s >> 1) ^ s) & 1;
        return (w << 2) | (s >> 1);
    endfunction
    function automatic int parf(int s, int u, int g);
        int w = (u ^ (s >> 1) ^ s) & 1;
        return ((g & w) ^ ((g >> 1) & (s >> 2)) ^ ((g >> 2) & (s >> 1)) ^ ((g >> 3) & s)) & 1;
    endfunction
    function automatic int corrf(int d, int k);
        int t;
        if (k >= 3) return 0;
        t = 40 >> k;
        return (d < t) ? ((t - d) >> 3) : 0;
    endfunction
    function automatic int gamf(int u, int p);
        return penf(int'(sys_in), 6, u) + penf(int'(par_in), 5, p);
    endfunction
    function automatic int betaf(int j);
        return int'((beta_in >> (7 * j)) & 56'h7f);
    endfunction

    task automatic model_next();
        for (int n = 0; n < 8; n++) begin
            int c[2];
            int d, best, dab;
            for (int r = 0; r < 2; r++) begin
                int s = ((n & 3) << 1) | r;
                int u = ((n >> 2) ^ n ^ r) & 1;
                c[r] = m7(m_al[s] + gamf(u, parf(s, u, int'(poly))));
            end
            d    = s7(c[0] - c[1]);
            best = (d > 0) ? c[1] : c[0];
            dab  = (d < 0) ? -d : d;
            n_al[n] = m7(best - corrf(dab, int'(scale_code)));
        end
        for (int u = 0; u < 2; u++) begin
            int best = 0;
            for (int s = 0; s < 8; s++) begin
                int t = m7(m_al[s] + gamf(u, parf(s, u, int'(poly))) + betaf(nxtf(s, u)));
                if (s == 0 || s7(t - best) < 0) best = t;
            end
            if (u == 0) n_mn0 = best; else n_mn1 = best;
        end
    endtask

    task automatic model_commit();
        if (step_en) begin
            int d = s7(m_mn0 - m_mn1);
            if (d > 31) d = 31;
            if (d < -31) d = -31;
            m_llr = d;
            m_mn0 = n_mn0;
            m_mn1 = n_mn1;
            for (int i = 0; i < 8; i++) m_al[i] = n_al[i];
        end
        if (clear) for (int i = 0; i < 8; i++) m_al[i] = (i == 0) ? 0 : 32;
    endtask

    task automatic check(string tag);
        int got = int'($signed(llr_out));
        checks++;
        if (got !== m_llr) begin
            errors++;
            $display("FAIL %s: llr_out=%0d expected=%0d at %0t", tag, got, m_llr, $time);
        end
    endtask

    task automatic step(input bit en, input bit clr, input int sys, input int par,
                        input logic [55:0] beta, input string tag);
        @(negedge clk);
        step_en = en; clear = clr;
        sys_in = 6'(sys); par_in = 5'(par); beta_in = beta;
        #1;
        model_next();
        @(posedge clk);
        #1;
        model_commit();
        check(tag);
    endtask

    function automatic logic [55:0] rbeta(int maxv);
        logic [55:0] b = '0;
        for (int j = 0; j < 8; j++) b[7*j +: 7] = 7'($urandom_range(maxv, 0));
        return b;
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1; step_en = 0; clear = 0; poly = 4'b1011; scale_code = 0;
        sys_in = 0; par_in = 0; beta_in = '0;
        for (int i = 0; i < 8; i++) m_al[i] = (i == 0) ? 0 : 32;
        m_mn0 = 0; m_mn1 = 0; m_llr = 0;
        repeat (3) @(posedge clk);
        #1; check("R10 reset output");
        @(negedge clk); rst = 0;

        // directed: strong samples, zero reverse metrics (R1 R2 R6 R7)
        step(1, 0, 6'd14, 5'd7,  '0, "R1 agree sys=+14");
        step(1, 0, 6'd46, 5'd23, '0, "R1 sys=-14 par=-7");
        step(1, 0, 6'd5,  5'd19, '0, "R2 mixed signs");
        step(1, 0, 6'd0,  5'd0,  '0, "R7 zero inputs");
        step(1, 0, 6'd31, 5'd15, '0, "R6 max magnitude");
        step(1, 0, 6'd63, 5'd31, '0, "R6 max negative");

        // reverse metric lane order (R9)
        for (int j = 0; j < 8; j++) begin
            logic [55:0] b = '0;
            b[7*j +: 7] = 7'd60;
            step(1, 0, int'($urandom_range(63, 0)), int'($urandom_range(31, 0)), b, "R9 beta lane");
        end

        // random mix across scales and tap patterns (R3 R4 R6)
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) begin
                poly = 4'($urandom_range(15, 0));
                scale_code = 3'((i / 50) % 6);
            end
            step(1, 0, int'($urandom_range(63, 0)), int'($urandom_range(31, 0)),
                 rbeta(127), (scale_code < 3) ? "R4 corrected step" : "R3 wrap compare");
        end

        // large reverse metrics to drive saturation (R6)
        scale_code = 3'd4;
        for (int i = 0; i < 40; i++) begin
            logic [55:0] b = rbeta(63);
            for (int j = 0; j < 4; j++) b[7*j +: 7] = 7'd0;
            step(1, 0, int'($urandom_range(63, 0)), int'($urandom_range(31, 0)), b, "R6 saturation");
        end

        // pause with moving inputs (R8)
        for (int i = 0; i < 6; i++)
            step(0, 0, int'($urandom_range(63, 0)), int'($urandom_range(31, 0)), rbeta(127), "R8 pause hold");
        for (int i = 0; i < 4; i++)
            step(1, 0, int'($urandom_range(63, 0)), int'($urandom_range(31, 0)), rbeta(127), "R8 resume");

        // clear during a step, during a pause (R5)
        scale_code = 3'd1;
        step(1, 1, 6'd9, 5'd3, rbeta(127), "R5 clear with step");
        for (int i = 0; i < 4; i++)
            step(1, 0, int'($urandom_range(63, 0)), int'($urandom_range(31, 0)), rbeta(127), "R5 after clear");
        step(0, 1, 6'd40, 5'd20, rbeta(127), "R5 clear while paused");
        for (int i = 0; i < 4; i++)
            step(1, 0, int'($urandom_range(63, 0)), int'($urandom_range(31, 0)), rbeta(127), "R5 restart");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule